// File: doc/BRIEF.md
# Per-Port Status Register Bank with Latching Event Bits

This block holds a small register set for each of four ports, and each register has its own access rule. Each port has five registers. The first shows its status inputs live. The second catches events and holds them until software reads them. The third catches alerts the same way and can also pull the port's interrupt line low. The fourth is a read/write enable mask for those alerts. The fifth is a write-only command register that forces alert bits set from software.

Software accesses the bank through a plain pulse interface. A single-cycle read strobe or write strobe carries a port number, a register address and, for writes, data. Read data is registered and appears the cycle after the strobe. It then holds until the next read. Reading an event or alert register clears it. The clear applies only to the port and address that were read. A source that is high in the same cycle as the clearing read keeps its bit set, so no event is lost. Each port drives an active-low interrupt output.

Top module: `sreg_bank`

## Requirements
- R1: After reset, every stored register bit is 0, `rdata_o` is 0 and every bit of `irq_n_o` is 1.
- R2: Reading address 0 returns the selected port's `status_i` value as it is on the read strobe cycle. Writes to address 0 change nothing.
- R3: Address 3 is the per-port interrupt mask. A write stores the data for the selected port only, and a read returns the stored value.
- R4: Address 4 is write-only. Reading it returns 0.
- R5: Address 1 holds event bits. A bit sets in the cycle after its `evt_src_i` bit is high, stays set after the source falls, and clears after a read of that port at address 1. The read returns the value from before the clear.
- R6: If an event or alert source bit is high in the same cycle as the clearing read, that bit is still set after the read.
- R7: A read clears only the register at the port and address that were read. Event and alert bits of other ports, and of other addresses, keep their values.
- R8: Address 2 holds alert bits, which latch and clear like event bits. `irq_n_o[p]` is 0 exactly when port p has an alert bit set whose mask bit is also set. Otherwise it is 1.
- R9: A write to address 4 sets, from the next cycle on, the alert bits of the selected port at the positions where the data is 1. It does not clear any bit.
- R10: Addresses 5 to 7 read as 0, and writes to them change no register.
- R11: `rdata_o` changes only in the cycle after a read strobe. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| port_i | input | PW (2) | Port selected by the access |
| addr_i | input | AW (3) | Register address within the port |
| wdata_i | input | DW (8) | Write data |
| status_i | input | NPORT x DW | Live status per port |
| evt_src_i | input | NPORT x DW | Event sources per port, high sets the bit |
| alr_src_i | input | NPORT x DW | Alert sources per port, high sets the bit |
| rdata_o | output | DW (8) | Registered read data |
| irq_n_o | output | NPORT (4) | Per-port interrupt, active low |

## Verification
The hardest case to reach is a source that goes high in the very cycle a clearing read lands on the same register. This must be tried both when the bit was already set and when it was not. The bench drives the read strobe and the source pulse from the same falling clock edge. It then checks that the read reports the old value and that the next read still finds the bit set. Isolation of the clear is checked by setting latches on one port and then reading the neighbouring port and the neighbouring address first.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    // Register addresses within one port
    localparam int unsigned ADDR_LIVE  = 0;
    localparam int unsigned ADDR_EVENT = 1;
    localparam int unsigned ADDR_ALERT = 2;
    localparam int unsigned ADDR_MASK  = 3;
    localparam int unsigned ADDR_FORCE = 4;

    // Access classes decoded from an address
    typedef enum logic [2:0] {
        ACC_LIVE,
        ACC_EVENT,
        ACC_ALERT,
        ACC_MASK,
        ACC_FORCE,
        ACC_NONE
    } acc_e;

    function automatic acc_e decode_addr(input int unsigned a);
        case (a)
            ADDR_LIVE:  return ACC_LIVE;
            ADDR_EVENT: return ACC_EVENT;
            ADDR_ALERT: return ACC_ALERT;
            ADDR_MASK:  return ACC_MASK;
            ADDR_FORCE: return ACC_FORCE;
            default:    return ACC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sreg_latch.sv
// Clear-on-read latch vector: a high source bit or a set bit makes the
// stored bit 1; a clear empties the vector but sources in the same cycle win.
module sreg_latch #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] set_i,
    input  logic          clr_i,
    output logic [DW-1:0] q_o
);

    typedef struct packed {
        logic [DW-1:0] bits;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.bits = '0;
        end
        st_d.bits = st_d.bits | src_i | set_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.bits;

endmodule

// File: rtl/sreg_rwreg.sv
// Plain read/write register with a write enable.
module sreg_rwreg #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] q_o
);

    typedef struct packed {
        logic [DW-1:0] val;
    } rw_t;

    rw_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.val = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.val;

endmodule

// File: rtl/sreg_rdmux.sv
// Selects the addressed register of the addressed port and registers it.
module sreg_rdmux
    import sreg_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    parameter int AW    = 3,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      rd_i,
    input  logic [PW-1:0]             port_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [NPORT-1:0][DW-1:0]  live_i,
    input  logic [NPORT-1:0][DW-1:0]  evt_i,
    input  logic [NPORT-1:0][DW-1:0]  alr_i,
    input  logic [NPORT-1:0][DW-1:0]  mask_i,
    output logic [DW-1:0]             rdata_o
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t           st_d, st_q;
    logic [DW-1:0] sel;
    acc_e          acc;

    always_comb begin
        acc = decode_addr(int'(addr_i));
        sel = '0;
        case (acc)
            ACC_LIVE:  sel = live_i[port_i];
            ACC_EVENT: sel = evt_i[port_i];
            ACC_ALERT: sel = alr_i[port_i];
            ACC_MASK:  sel = mask_i[port_i];
            default:   sel = '0;   // write-only and unmapped read as zero
        endcase

        st_d = st_q;
        if (rd_i) begin
            st_d.rdata = sel;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/sreg_irq.sv
// Per-port active-low interrupt from masked alert bits.
module sreg_irq #(
    parameter int NPORT = 4,
    parameter int DW    = 8
) (
    input  logic [NPORT-1:0][DW-1:0] alr_i,
    input  logic [NPORT-1:0][DW-1:0] mask_i,
    output logic [NPORT-1:0]         irq_n_o
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [DW-1:0] pend;
        always_comb begin
            pend         = alr_i[p] & mask_i[p];
            irq_n_o[p]   = ~(|pend);
        end
    end

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    parameter int AW    = 3,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      rd_i,
    input  logic                      wr_i,
    input  logic [PW-1:0]             port_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [DW-1:0]             wdata_i,
    input  logic [NPORT-1:0][DW-1:0]  status_i,
    input  logic [NPORT-1:0][DW-1:0]  evt_src_i,
    input  logic [NPORT-1:0][DW-1:0]  alr_src_i,
    output logic [DW-1:0]             rdata_o,
    output logic [NPORT-1:0]          irq_n_o
);

    logic [NPORT-1:0][DW-1:0] ev_q;
    logic [NPORT-1:0][DW-1:0] al_q;
    logic [NPORT-1:0][DW-1:0] mask_q;
    acc_e                     acc;

    always_comb begin
        acc = decode_addr(int'(addr_i));
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic          hit;
        logic          clr_ev;
        logic          clr_al;
        logic          we_mask;
        logic [DW-1:0] force_bits;

        always_comb begin
            hit        = (port_i == PW'(p));
            clr_ev     = rd_i && hit && (acc == ACC_EVENT);
            clr_al     = rd_i && hit && (acc == ACC_ALERT);
            we_mask    = wr_i && hit && (acc == ACC_MASK);
            force_bits = (wr_i && hit && (acc == ACC_FORCE)) ? wdata_i : '0;
        end

        sreg_latch #(.DW(DW)) i_evt (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .src_i (evt_src_i[p]),
            .set_i ({DW{1'b0}}),
            .clr_i (clr_ev),
            .q_o   (ev_q[p])
        );

        sreg_latch #(.DW(DW)) i_alr (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .src_i (alr_src_i[p]),
            .set_i (force_bits),
            .clr_i (clr_al),
            .q_o   (al_q[p])
        );

        sreg_rwreg #(.DW(DW)) i_mask (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .we_i    (we_mask),
            .wdata_i (wdata_i),
            .q_o     (mask_q[p])
        );
    end

    sreg_rdmux #(.NPORT(NPORT), .DW(DW), .AW(AW)) i_rdmux (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rd_i    (rd_i),
        .port_i  (port_i),
        .addr_i  (addr_i),
        .live_i  (status_i),
        .evt_i   (ev_q),
        .alr_i   (al_q),
        .mask_i  (mask_q),
        .rdata_o (rdata_o)
    );

    sreg_irq #(.NPORT(NPORT), .DW(DW)) i_irq (
        .alr_i   (al_q),
        .mask_i  (mask_q),
        .irq_n_o (irq_n_o)
    );

endmodule

// File: rtl/sreg_bank_chk.sv
module sreg_bank_chk
    import sreg_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    parameter int AW    = 3,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic                      rd_i,
    input logic                      wr_i,
    input logic [PW-1:0]             port_i,
    input logic [AW-1:0]             addr_i,
    input logic [NPORT-1:0][DW-1:0]  evt_src_i,
    input logic [NPORT-1:0][DW-1:0]  alr_src_i,
    input logic [DW-1:0]             rdata_o,
    input logic [NPORT-1:0]          irq_n_o,
    input logic [NPORT-1:0][DW-1:0]  ev_q,
    input logic [NPORT-1:0][DW-1:0]  al_q,
    input logic [NPORT-1:0][DW-1:0]  mask_q
);

    // R11: read data only moves after a read strobe
    p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |=> $stable(rdata_o));

    // R4: the write-only register reads as zero
    p_force_reads_zero_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && addr_i == AW'(ADDR_FORCE)) |=> (rdata_o == '0));

    // R10: unmapped addresses read as zero
    p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && addr_i > AW'(ADDR_FORCE)) |=> (rdata_o == '0));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R5: a high source bit is latched in the next cycle
        p_evt_set_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            (evt_src_i[p] != '0) |=>
                ((ev_q[p] & $past(evt_src_i[p])) == $past(evt_src_i[p])));

        // R7: without a read of this port's event register no bit drops
        p_evt_keep_r7: assert property (@(posedge clk_i) disable iff (rst_i)
            !(rd_i && port_i == PW'(p) && addr_i == AW'(ADDR_EVENT)) |=>
                ((ev_q[p] & $past(ev_q[p])) == $past(ev_q[p])));

        // R6: an alert source seen on the clearing read survives it
        p_alr_race_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_i && port_i == PW'(p) && addr_i == AW'(ADDR_ALERT)) |=>
                ((al_q[p] & $past(alr_src_i[p])) == $past(alr_src_i[p])));

        // R8: a port with an empty mask never requests an interrupt
        p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (rst_i)
            (mask_q[p] == '0) |-> irq_n_o[p]);

        // R7: a read of the alert register with no new source empties it
        p_alr_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_i && !wr_i && port_i == PW'(p) && addr_i == AW'(ADDR_ALERT)
             && alr_src_i[p] == '0) |=> (al_q[p] == '0));
    end

endmodule

bind sreg_bank sreg_bank_chk #(.NPORT(NPORT), .DW(DW), .AW(AW)) i_chk (.*);

// File: tb/test_sreg_bank.sv
`timescale 1ns/1ps
module test_sreg_bank;

    localparam int NPORT = 4;
    localparam int DW    = 8;
    localparam int AW    = 3;

    localparam logic [2:0] A_LIVE  = 3'd0;
    localparam logic [2:0] A_EVENT = 3'd1;
    localparam logic [2:0] A_ALERT = 3'd2;
    localparam logic [2:0] A_MASK  = 3'd3;
    localparam logic [2:0] A_FORCE = 3'd4;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     rd = 1'b0;
    logic                     wr = 1'b0;
    logic [1:0]               port = '0;
    logic [AW-1:0]            addr = '0;
    logic [DW-1:0]            wdata = '0;
    logic [NPORT-1:0][DW-1:0] status = '0;
    logic [NPORT-1:0][DW-1:0] ev_src = '0;
    logic [NPORT-1:0][DW-1:0] al_src = '0;
    logic [DW-1:0]            rdata;
    logic [NPORT-1:0]         irq_n;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    sreg_bank #(.NPORT(NPORT), .DW(DW), .AW(AW)) i_sreg_bank (
        .clk_i     (clk),
        .rst_i     (rst),
        .rd_i      (rd),
        .wr_i      (wr),
        .port_i    (port),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .status_i  (status),
        .evt_src_i (ev_src),
        .alr_src_i (al_src),
        .rdata_o   (rdata),
        .irq_n_o   (irq_n)
    );

    typedef struct packed {
        logic       is_wr;
        logic [1:0] p;
        logic [2:0] a;
        logic [7:0] d;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd0, 3'd3, 8'h5A, 8'h00, 4'd3},   // R3 write mask p0
        '{1'b1, 2'd3, 3'd3, 8'hC3, 8'h00, 4'd3},   // R3 write mask p3
        '{1'b0, 2'd0, 3'd3, 8'h00, 8'h5A, 4'd3},   // R3 read back p0
        '{1'b0, 2'd3, 3'd3, 8'h00, 8'hC3, 4'd3},   // R3 read back p3
        '{1'b0, 2'd1, 3'd3, 8'h00, 8'h00, 4'd3},   // R3 p1 untouched
        '{1'b1, 2'd0, 3'd0, 8'hFF, 8'h00, 4'd2},   // R2 write to live
        '{1'b0, 2'd0, 3'd0, 8'h00, 8'hA0, 4'd2},   // R2 live still input
        '{1'b0, 2'd2, 3'd0, 8'h00, 8'hA2, 4'd2},   // R2 live p2
        '{1'b1, 2'd1, 3'd4, 8'h05, 8'h00, 4'd9},   // R9 force p1
        '{1'b0, 2'd1, 3'd4, 8'h00, 8'h00, 4'd4},   // R4 force reads zero
        '{1'b0, 2'd1, 3'd2, 8'h00, 8'h05, 4'd9},   // R9 forced alert bits
        '{1'b0, 2'd1, 3'd2, 8'h00, 8'h00, 4'd5},   // R5 cleared by read
        '{1'b1, 2'd2, 3'd6, 8'h77, 8'h00, 4'd10},  // R10 unmapped write
        '{1'b0, 2'd2, 3'd6, 8'h00, 8'h00, 4'd10},  // R10 unmapped read
        '{1'b0, 2'd2, 3'd7, 8'h00, 8'h00, 4'd10},  // R10 unmapped read
        '{1'b0, 2'd2, 3'd3, 8'h00, 8'h00, 4'd10}   // R10 mask not hit
    };

    task automatic check(input string req, input logic [7:0] got,
                         input logic [7:0] exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] p, input logic [2:0] a,
                            input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; port = p; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] p, input logic [2:0] a,
                           output logic [7:0] got);
        @(negedge clk);
        rd = 1'b1; port = p; addr = a;
        @(negedge clk);
        rd = 1'b0;
        got = rdata;
    endtask

    task automatic pulse_ev(input int p, input logic [7:0] b);
        @(negedge clk);
        ev_src[p] = b;
        @(negedge clk);
        ev_src[p] = '0;
    endtask

    task automatic pulse_al(input int p, input logic [7:0] b);
        @(negedge clk);
        al_src[p] = b;
        @(negedge clk);
        al_src[p] = '0;
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_sim();
        end
    end

    initial begin
        logic [7:0] got;
        for (int p = 0; p < NPORT; p++) status[p] = 8'hA0 | 8'(p);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", rdata, 8'h00, "rdata after reset");
        check("R1", {4'h0, irq_n}, 8'h0F, "irq_n after reset");
        do_read(2'd2, A_MASK, got);
        check("R1", got, 8'h00, "mask after reset");
        do_read(2'd1, A_EVENT, got);
        check("R1", got, 8'h00, "event after reset");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].is_wr) begin
                do_write(VEC[i].p, VEC[i].a, VEC[i].d);
            end else begin
                do_read(VEC[i].p, VEC[i].a, got);
                check($sformatf("R%0d", VEC[i].req), got, VEC[i].exp,
                      $sformatf("vector %0d", i));
            end
        end

        // R5 latch and clear on read
        pulse_ev(2, 8'h08);
        repeat (2) @(negedge clk);
        do_read(2'd2, A_EVENT, got);
        check("R5", got, 8'h08, "event held after source fell");
        do_read(2'd2, A_EVENT, got);
        check("R5", got, 8'h00, "event cleared by read");

        // R7 clear is local to port and address
        pulse_ev(0, 8'h01);
        pulse_al(0, 8'h40);
        do_read(2'd1, A_EVENT, got);
        check("R7", got, 8'h00, "other port event");
        do_read(2'd0, A_ALERT, got);
        check("R7", got, 8'h40, "alert of same port");
        do_read(2'd0, A_EVENT, got);
        check("R7", got, 8'h01, "event survived other reads");
        do_read(2'd0, A_EVENT, got);
        check("R7", got, 8'h00, "event cleared");

        // R6 source high on the clearing read, bit previously clear
        @(negedge clk);
        rd = 1'b1; port = 2'd3; addr = A_EVENT; ev_src[3] = 8'h02;
        @(negedge clk);
        rd = 1'b0; ev_src[3] = '0;
        check("R6", rdata, 8'h00, "read returns old value");
        do_read(2'd3, A_EVENT, got);
        check("R6", got, 8'h02, "racing source kept");
        do_read(2'd3, A_EVENT, got);
        check("R6", got, 8'h00, "cleared afterwards");

        // R6 bit already set and source high again on the read
        pulse_ev(3, 8'h10);
        @(negedge clk);
        rd = 1'b1; port = 2'd3; addr = A_EVENT; ev_src[3] = 8'h10;
        @(negedge clk);
        rd = 1'b0; ev_src[3] = '0;
        check("R6", rdata, 8'h10, "read sees set bit");
        do_read(2'd3, A_EVENT, got);
        check("R6", got, 8'h10, "bit still set after race");
        do_read(2'd3, A_EVENT, got);
        check("R6", got, 8'h00, "bit clear after quiet read");

        // R8 interrupt follows masked alerts
        do_write(2'd1, A_MASK, 8'h01);
        pulse_al(1, 8'h02);
        check("R8", {4'h0, irq_n}, 8'h0F, "unmasked alert gives no irq");
        pulse_al(1, 8'h01);
        check("R8", {4'h0, irq_n}, 8'h0D, "masked alert raises irq p1");
        do_read(2'd1, A_ALERT, got);
        check("R8", got, 8'h03, "alert bits read");
        check("R8", {4'h0, irq_n}, 8'h0F, "irq released after read");

        // R9 force write raises interrupt
        do_write(2'd2, A_MASK, 8'h80);
        do_write(2'd2, A_FORCE, 8'h80);
        check("R9", {4'h0, irq_n}, 8'h0B, "forced alert irq p2");
        do_read(2'd2, A_ALERT, got);
        check("R9", got, 8'h80, "forced bit read");
        check("R9", {4'h0, irq_n}, 8'h0F, "irq released");

        // R11 read data holds while no read; R2 live follows input
        do_read(2'd0, A_LIVE, got);
        check("R11", got, 8'hA0, "live read");
        status[0] = 8'h3C;
        repeat (3) @(negedge clk);
        check("R11", rdata, 8'hA0, "rdata held without read");
        do_read(2'd0, A_LIVE, got);
        check("R2", got, 8'h3C, "live value updated");

        done = 1'b1;
        finish_sim();
    end

endmodule